// File: doc/BRIEF.md
# Sixteen-Line GPIO with Per-Line Interrupt Detection

This block gives a chip sixteen general-purpose pins behind a small register port. Software sets the value each pin drives and chooses, line by line, whether the pin drives or only listens. It can read back the synchronized level of every pin at any time. The pads connect through separate input, output and drive-enable vectors.

Each line also has its own interrupt detector. Software picks one of five detection styles per line: level high, level low, rising edge, falling edge, or any change. The style fields are 3 bits wide and are packed eight lines to a register, so two registers cover the sixteen lines. A detected event sets a sticky status bit. Software clears that bit by writing a 1 to its position. A level-style bit comes straight back while the pin still meets its condition. Every status bit is driven out on its own interrupt request line toward an interrupt controller.

Register map, at the 3-bit word address `req_addr`:

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | drive | read/write | bits 15:0 hold the value driven on each pin |
| 1 | direction | read/write | bits 15:0 hold each line's direction: 1 means input, 0 means drive |
| 2 | level | read only | bits 15:0 hold the synchronized pin levels |
| 3 | style for lines 0 to 7 | read/write | line n's field is bits [3n+2:3n] |
| 4 | style for lines 8 to 15 | read/write | line n's field is bits [3(n-8)+2:3(n-8)] |
| 5 | status | write 1 to clear | bits 15:0 hold the sticky event flags |

A read returns data one cycle after the request. Bits above the used width read as 0.

Top module: `gpio_irq_unit`

## Requirements
- R1: After a synchronous reset, the following hold:
  - the drive register, both style registers and the status register are zero;
  - the direction register is 16'hFFFF, so every line is an input;
  - `pin_oe` and `irq` are zero.
- R2: `pin_out` equals the drive register. `pin_oe[n]` is 1 exactly when direction bit n is 0.
- R3: Each pin passes through a two-flop synchronizer. A level applied to `pin_in` is visible at address 2 two clock edges later.
- R4: Line n's style field sits at address 3 for n < 8 and at address 4 for n >= 8, in bits [3(n mod 8)+2 : 3(n mod 8)]. The style registers read back what was written in bits 23:0. Codes 5, 6 and 7 disable detection for that line.
- R5: Code 0 (level high) sets the status bit while the synchronized pin is 1. Code 1 (level low) sets it while the pin is 0.
- R6: Code 2 (rising) sets the status bit when the synchronized level goes from 0 to 1. Code 3 (falling) sets it when the level goes from 1 to 0.
- R7: Code 4 (any change) sets the status bit on both rising and falling changes.
- R8: Writing to address 5 clears every status bit whose data bit is 1. Bits written as 0 keep their value.
- R9: A level-style status bit stays set after a clear for as long as its pin condition holds. It can only be cleared once the condition has gone away.
- R10: `irq[n]` equals status bit n.
- R11: Read data is registered. It updates one cycle after a read request and holds its value otherwise. Addresses 6 and 7 read 0. Writes to address 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register word address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Pin levels from the pads, asynchronous |
| pin_out | output | 16 | Value driven toward the pads |
| pin_oe | output | 16 | Drive enable per pin, 1 = drive |
| irq | output | 16 | Interrupt request per line |

## Verification
The assertions assume the following about the inputs:
- `rst` is held for several cycles, so the reset values of the synchronizer and of the previous-sample register are settled before any edge check looks back.
- A status bit only rises under an edge style when the synchronized level differs from its previous sample. The edge-origin check therefore uses the style as it was on the edge before the rise.

The stimulus drives pins and register requests only on the falling clock edge, so the sampled values are clean. It issues at most one register access per cycle. In the directed part it holds each pin level for at least three cycles before checking a flag. A random phase then toggles pins every cycle and fires clears at random, with a behavioural model tracking every output.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int STYLE_W       = 3;
  localparam int LINES_PER_REG = 8;
  localparam int STYLE_BITS    = STYLE_W * LINES_PER_REG;

  localparam logic [STYLE_W-1:0] STY_HIGH = 3'd0;
  localparam logic [STYLE_W-1:0] STY_LOW  = 3'd1;
  localparam logic [STYLE_W-1:0] STY_RISE = 3'd2;
  localparam logic [STYLE_W-1:0] STY_FALL = 3'd3;
  localparam logic [STYLE_W-1:0] STY_BOTH = 3'd4;

  typedef enum logic [2:0] {
    RA_DRIVE  = 3'd0,
    RA_DIR    = 3'd1,
    RA_LEVEL  = 3'd2,
    RA_STY_LO = 3'd3,
    RA_STY_HI = 3'd4,
    RA_STAT   = 3'd5
  } reg_addr_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [N-1:0] stage_q;
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= din;
      end
      assign dout = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0][N-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
      assign dout = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N-1:0]               lvl,
  input  logic [N-1:0][STYLE_W-1:0]  style,
  input  logic [N-1:0]               clr,
  output logic [N-1:0]               stat
);

  logic [N-1:0] prev_q;
  logic [N-1:0] hit;
  logic [N-1:0] stat_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      logic c;
      always_comb begin
        case (style[i])
          STY_HIGH: c = lvl[i];
          STY_LOW:  c = ~lvl[i];
          STY_RISE: c = lvl[i] & ~prev_q[i];
          STY_FALL: c = ~lvl[i] & prev_q[i];
          STY_BOTH: c = lvl[i] ^ prev_q[i];
          default:  c = 1'b0;
        endcase
      end
      assign hit[i] = c;

      // R8: a bit not being cleared keeps its value
      a_r8_no_clear_holds: assert property (@(posedge clk) disable iff (rst)
        (stat_q[i] && !clr[i]) |=> stat_q[i]);

      // R9: a level condition that holds forces the flag on the next edge
      a_r9_level_sticks: assert property (@(posedge clk) disable iff (rst)
        ((style[i] == STY_HIGH && lvl[i]) || (style[i] == STY_LOW && !lvl[i])) |=> stat_q[i]);

      // R6: an edge-style flag only rises after a change of the sampled level
      a_r6_edge_origin: assert property (@(posedge clk) disable iff (rst)
        ($rose(stat_q[i]) && ($past(style[i]) == STY_RISE || $past(style[i]) == STY_FALL ||
                              $past(style[i]) == STY_BOTH))
        |-> ($past(lvl[i]) != $past(prev_q[i])));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl;
      stat_q <= (stat_q & ~clr) | hit;
    end
  end

  assign stat = stat_q;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int N      = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic [DATA_W-1:0]         rsp_rdata,
  input  logic [N-1:0]              lvl,
  input  logic [N-1:0]              stat,
  output logic [N-1:0]              drive_q,
  output logic [N-1:0]              dir_q,
  output logic [N-1:0][STYLE_W-1:0] style,
  output logic [N-1:0]              clr
);

  localparam int PAD_N = DATA_W - N;
  localparam int PAD_S = DATA_W - STYLE_BITS;

  logic [STYLE_BITS-1:0] sty_lo_q;
  logic [STYLE_BITS-1:0] sty_hi_q;
  logic [DATA_W-1:0]     rdata_q;
  logic [DATA_W-1:0]     rd_mux;
  logic                  wr_en;
  logic                  rd_en;
  reg_addr_e             addr;

  assign wr_en = req_valid && req_write;
  assign rd_en = req_valid && !req_write;
  assign addr  = reg_addr_e'(req_addr);
  assign clr   = (wr_en && addr == RA_STAT) ? req_wdata[N-1:0] : '0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_sty
      if (i < LINES_PER_REG) begin : g_lo
        assign style[i] = sty_lo_q[i*STYLE_W +: STYLE_W];
      end else begin : g_hi
        assign style[i] = sty_hi_q[(i-LINES_PER_REG)*STYLE_W +: STYLE_W];
      end
    end
  endgenerate

  always_comb begin
    case (addr)
      RA_DRIVE:  rd_mux = {{PAD_N{1'b0}}, drive_q};
      RA_DIR:    rd_mux = {{PAD_N{1'b0}}, dir_q};
      RA_LEVEL:  rd_mux = {{PAD_N{1'b0}}, lvl};
      RA_STY_LO: rd_mux = {{PAD_S{1'b0}}, sty_lo_q};
      RA_STY_HI: rd_mux = {{PAD_S{1'b0}}, sty_hi_q};
      RA_STAT:   rd_mux = {{PAD_N{1'b0}}, stat};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q  <= '0;
      dir_q    <= '1;
      sty_lo_q <= '0;
      sty_hi_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          RA_DRIVE:  drive_q  <= req_wdata[N-1:0];
          RA_DIR:    dir_q    <= req_wdata[N-1:0];
          RA_STY_LO: sty_lo_q <= req_wdata[STYLE_BITS-1:0];
          RA_STY_HI: sty_hi_q <= req_wdata[STYLE_BITS-1:0];
          default:   ;
        endcase
      end
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rsp_rdata = rdata_q;

  // R11: read data only moves after a read request
  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rsp_rdata));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_pkg::*;
#(
  parameter int N           = 16,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic [N-1:0]      irq
);

  logic [N-1:0]              lvl;
  logic [N-1:0]              stat;
  logic [N-1:0]              drive_q;
  logic [N-1:0]              dir_q;
  logic [N-1:0]              clr;
  logic [N-1:0][STYLE_W-1:0] style;

  gpio_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (lvl)
  );

  gpio_regs #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .lvl       (lvl),
    .stat      (stat),
    .drive_q   (drive_q),
    .dir_q     (dir_q),
    .style     (style),
    .clr       (clr)
  );

  gpio_detect #(.N(N)) u_detect (
    .clk   (clk),
    .rst   (rst),
    .lvl   (lvl),
    .style (style),
    .clr   (clr),
    .stat  (stat)
  );

  assign pin_out = drive_q;
  assign pin_oe  = ~dir_q;
  assign irq     = stat;

endmodule

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit started = 0;

  always #5 clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference
  logic [15:0] m_drv, m_dir, m_s1, m_s2, m_prev, m_stat;
  logic [23:0] m_lo, m_hi;
  logic [31:0] m_rd;

  function automatic logic [2:0] sty_of(int n, logic [23:0] lo, logic [23:0] hi);
    return (n < 8) ? lo[3*n +: 3] : hi[3*(n-8) +: 3];
  endfunction

  always @(posedge clk) begin
    logic [15:0] hit, clrm;
    logic [31:0] rd;
    started = 1;
    if (rst) begin
      m_drv = 0; m_dir = 16'hFFFF; m_s1 = 0; m_s2 = 0; m_prev = 0;
      m_stat = 0; m_lo = 0; m_hi = 0; m_rd = 0;
    end else begin
      for (int n = 0; n < 16; n++) begin
        int s;
        s = sty_of(n, m_lo, m_hi);
        hit[n] = (s == 0) ? m_s2[n] :
                 (s == 1) ? !m_s2[n] :
                 (s == 2) ? (m_s2[n] && !m_prev[n]) :
                 (s == 3) ? (!m_s2[n] && m_prev[n]) :
                 (s == 4) ? (m_s2[n] != m_prev[n]) : 1'b0;
      end
      clrm = (req_valid && req_write && req_addr == 5) ? req_wdata[15:0] : 16'h0;
      case (req_addr)
        0: rd = {16'h0, m_drv};
        1: rd = {16'h0, m_dir};
        2: rd = {16'h0, m_s2};
        3: rd = {8'h0, m_lo};
        4: rd = {8'h0, m_hi};
        5: rd = {16'h0, m_stat};
        default: rd = 0;
      endcase
      if (req_valid && !req_write) m_rd = rd;
      if (req_valid && req_write) begin
        case (req_addr)
          0: m_drv = req_wdata[15:0];
          1: m_dir = req_wdata[15:0];
          3: m_lo  = req_wdata[23:0];
          4: m_hi  = req_wdata[23:0];
          default: ;
        endcase
      end
      m_stat = (m_stat & ~clrm) | hit;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pin_in;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      check("R10 irq vs model status", {16'h0, irq}, {16'h0, m_stat});
      check("R2 pin_out vs model", {16'h0, pin_out}, {16'h0, m_drv});
      check("R2 pin_oe vs model", {16'h0, pin_oe}, {16'h0, ~m_dir});
      check("R11 rdata vs model", rsp_rdata, m_rd);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    tick(4);
    rst = 0;
    tick(1);
    // R1 reset state
    rd(1, d); check("R1 direction resets to inputs", d, 32'h0000FFFF);
    rd(5, d); check("R1 status resets to zero", d, 0);
    rd(3, d); check("R1 style resets to zero", d, 0);
    check("R1 pin_oe after reset", {16'h0, pin_oe}, 0);
    check("R1 irq after reset", {16'h0, irq}, 0);

    // R2 drive and direction
    wr(0, 32'hA5A5);
    wr(1, 32'h0F0F);
    check("R2 pin_out follows drive", {16'h0, pin_out}, 32'hA5A5);
    check("R2 pin_oe is inverse direction", {16'h0, pin_oe}, 32'hF0F0);

    // disable detection everywhere, then R3 level read
    wr(3, 32'hFFFFFF);
    wr(4, 32'hFFFFFF);
    pin_in = 16'h1234;
    tick(3);
    rd(2, d); check("R3 level read", d, 32'h1234);
    rd(5, d); check("R4 disabled codes set nothing", d, 0);
    pin_in = 16'h0000;
    tick(3);

    // per-line styles
    wr(3, 32'hFAC688);
    wr(4, 32'h3FFFFA);
    rd(4, d); check("R4 upper style readback", d, 32'h3FFFFA);
    rd(3, d); check("R4 lower style readback", d, 32'hFAC688);
    tick(2);
    check("R5 active-low line1 with pin low", {31'h0, irq[1]}, 1);
    check("R4 upper line15 active-low", {31'h0, irq[15]}, 1);

    pin_in[0] = 1; pin_in[2] = 1; pin_in[5] = 1;
    tick(3);
    check("R5 active-high line0", {31'h0, irq[0]}, 1);
    check("R6 rising line2", {31'h0, irq[2]}, 1);
    check("R4 code 5 line5 ignored", {31'h0, irq[5]}, 0);

    wr(5, 32'h0004);
    tick(1);
    check("R8 write-1 clears line2", {31'h0, irq[2]}, 0);
    check("R8 write-0 keeps line0", {31'h0, irq[0]}, 1);
    wr(5, 32'h0001);
    tick(1);
    check("R9 level flag persists after clear", {31'h0, irq[0]}, 1);
    pin_in[0] = 0;
    tick(3);
    wr(5, 32'h0001);
    tick(1);
    check("R9 level flag clears once condition gone", {31'h0, irq[0]}, 0);

    pin_in[3] = 1;
    tick(3);
    check("R6 falling ignores rise", {31'h0, irq[3]}, 0);
    pin_in[3] = 0;
    tick(3);
    check("R6 falling line3", {31'h0, irq[3]}, 1);

    pin_in[4] = 1;
    tick(3);
    check("R7 any-change on rise", {31'h0, irq[4]}, 1);
    wr(5, 32'h0010);
    tick(1);
    check("R7 cleared", {31'h0, irq[4]}, 0);
    pin_in[4] = 0;
    tick(3);
    check("R7 any-change on fall", {31'h0, irq[4]}, 1);

    pin_in[8] = 1;
    tick(3);
    check("R4 upper line8 rising", {31'h0, irq[8]}, 1);

    // R11 unused address and write to level register
    rd(7, d); check("R11 unused address reads zero", d, 0);
    wr(2, 32'hFFFF);
    rd(2, d); check("R11 level write ignored", d, {16'h0, pin_in});

    // random phase, model compares every clock
    for (int k = 0; k < 400; k++) begin
      pin_in = 16'($urandom);
      if (k % 7 == 0) wr(5, $urandom);
      else if (k % 11 == 0) rd(3'($urandom_range(0, 5)), d);
      else tick(1);
    end
    tick(3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule